// File: doc/BRIEF.md
# Dual-Byte-Strobe DRAM Cycle Decoder

This block is the control front end of a DRAM that has one row strobe and two column strobes, one for each byte lane. A fast system clock oversamples the active-low strobe pins, write enable, output enable and the multiplexed address. From the order in which those samples change, the block works out what kind of memory cycle the controller is running. It also latches the row and column addresses, keeps the internal refresh row counter, and produces per-lane read-drive enables and write strobes for the storage array next to it.

The two byte strobes are merged into one internal column strobe. That strobe becomes active with the first byte strobe to fall and goes inactive only after the last one has risen. Each cycle is classified as a counter-driven refresh, a row-only refresh, an early write, a late write or a read. Every output is registered. A pin change first passes through one sampling register and then one output register, so it reaches the outputs after two clock edges.

Top module: `dram_strobe_decoder`

## Requirements
- R1: The internal column strobe is active while either byte strobe is low. The column address is latched only when the internal strobe goes from inactive to active. A second lane falling while the other lane is still low does not relatch the column, and neither does one lane rising and falling again while the other stays low.
- R2: If the internal column strobe is active when the row strobe falls, the cycle is a counter refresh. cyc_type becomes 1 and row_addr takes the refresh counter value. The address pins are ignored for the rest of the cycle. rd_lane_en and wr_lane_stb stay 0 whatever OE and WE do.
- R3: When the row strobe rises at the end of a counter refresh, ref_stb pulses for one cycle and ref_row carries the counter value. The 9-bit counter then increments, wrapping from 511 to 0.
- R4: If the row strobe falls and then rises with no column strobe fall in between, cyc_type becomes 2 (row-only refresh).
- R5: If WE is low when the internal column strobe falls, cyc_type becomes 3 (early write). Any lane whose strobe falls while WE is low gets a one-cycle wr_lane_stb pulse. rd_lane_en stays 0 until the next column strobe fall, even if WE rises and OE falls in the meantime.
- R6: Suppose the internal column strobe is active and the cycle is not an early write. A WE fall with OE high then sets cyc_type to 4 (late write) and pulses wr_lane_stb for every lane that is currently low. A WE fall with OE low produces no strobe and leaves cyc_type unchanged.
- R7: cyc_type becomes 5 (read) when the column strobe and OE are both active with WE high. This happens whichever of the two falls later.
- R8: rd_lane_en bit 0 belongs to the lower byte strobe and bit 1 to the upper one. A lane is newly enabled only when its own strobe, OE low, WE high and the row strobe are all active during a read access. Raising OE turns the enable off.
- R9: During a read, a lane's enable remains set after its strobe rises while the row strobe is still low. It is held until the next internal column strobe fall, and at that fall it drops unless the lane is selected again.
- R10: While the row strobe is high, rd_lane_en is 0.
- R11: At the row strobe rise that ends any access or row-only cycle, ref_stb pulses for one cycle and ref_row carries that cycle's latched row.
- R12: After synchronous reset all outputs are 0 and the refresh counter starts at 0. Every output responds to a pin change two clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower byte column strobe, active low |
| ucas_n | input | 1 | Upper byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| cyc_type | output | 3 | 0 open, 1 counter refresh, 2 row-only, 3 early write, 4 late write, 5 read |
| row_addr | output | ADDR_W | Latched row (counter value in counter refresh) |
| col_addr | output | ADDR_W | Latched column |
| rd_lane_en | output | 2 | Per-lane output drive enable |
| wr_lane_stb | output | 2 | Per-lane one-cycle write strobe |
| ref_stb | output | 1 | Row refreshed pulse |
| ref_row | output | ADDR_W | Row refreshed with ref_stb |

## Verification
Some properties are checked by assertions on every cycle. An internal strobe fall always comes with at least one lane fall. A drive enable never appears without the row strobe active one sample earlier. A lane never drives and writes in the same cycle. A counter refresh never drives or writes. Every ref_stb follows a row strobe rise. The counter either holds or steps by exactly one.

Other behaviour depends on the order of edges, so only the bench scenarios can show it. These are the choice between read and late write, the early-write lockout after WE returns high, the data hold across strobe precharge, the first-fall/last-rise column latching, and the counter wrap after 512 refreshes.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  localparam int LANES = 2;

  typedef enum logic [2:0] {
    CYC_NONE    = 3'd0,
    CYC_CBR     = 3'd1,
    CYC_RASONLY = 3'd2,
    CYC_EWR     = 3'd3,
    CYC_LWR     = 3'd4,
    CYC_READ    = 3'd5
  } cyc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ROW  = 2'd1,
    ST_ACC  = 2'd2,
    ST_CBR  = 2'd3
  } st_e;

  typedef struct packed {
    logic ras_act;
    logic ras_fall;
    logic ras_rise;
    logic cas_act;
    logic cas_fall;
    logic we_low;
    logic we_fall;
    logic oe_low;
    logic oe_fall;
  } evt_t;
endpackage

// File: rtl/dsd_pin_sampler.sv
module dsd_pin_sampler
  import dsd_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int NLANE  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic [NLANE-1:0]  cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output evt_t              evt,
  output logic [NLANE-1:0]  lane_act,
  output logic [NLANE-1:0]  lane_fall,
  output logic [ADDR_W-1:0] addr_s
);
  // active-high internal copies: current sample and the one before
  logic s_ras, p_ras, s_we, p_we, s_oe, p_oe;
  logic [NLANE-1:0] s_cas, p_cas;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ras  <= 1'b0;
      p_ras  <= 1'b0;
      s_we   <= 1'b0;
      p_we   <= 1'b0;
      s_oe   <= 1'b0;
      p_oe   <= 1'b0;
      s_cas  <= '0;
      p_cas  <= '0;
      addr_s <= '0;
    end else begin
      s_ras  <= ~ras_n;
      p_ras  <= s_ras;
      s_we   <= ~we_n;
      p_we   <= s_we;
      s_oe   <= ~oe_n;
      p_oe   <= s_oe;
      s_cas  <= ~cas_n;
      p_cas  <= s_cas;
      addr_s <= addr;
    end
  end

  generate
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
      assign lane_fall[g] = s_cas[g] & ~p_cas[g];
    end
  endgenerate

  assign lane_act = s_cas;

  always_comb begin
    evt.ras_act  = s_ras;
    evt.ras_fall = s_ras & ~p_ras;
    evt.ras_rise = ~s_ras & p_ras;
    evt.cas_act  = |s_cas;                  // first fall in, last rise out
    evt.cas_fall = (|s_cas) & ~(|p_cas);
    evt.we_low   = s_we;
    evt.we_fall  = s_we & ~p_we;
    evt.oe_low   = s_oe;
    evt.oe_fall  = s_oe & ~p_oe;
  end

  // R1
  casfall_has_lane_chk: assert property (@(posedge clk) disable iff (rst)
    evt.cas_fall |-> (lane_fall != '0));
endmodule

// File: rtl/dsd_refresh_ctr.sv
module dsd_refresh_ctr #(
  parameter int REF_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [REF_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    inc |=> (cnt == REF_W'($past(cnt) + 1'b1)));
  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(cnt));
endmodule

// File: rtl/dsd_cycle_fsm.sv
module dsd_cycle_fsm
  import dsd_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int NLANE  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  evt_t              evt,
  input  logic [NLANE-1:0]  lane_act,
  input  logic [NLANE-1:0]  lane_fall,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [ADDR_W-1:0] ref_cnt,
  output cyc_e              cyc_q,
  output logic [ADDR_W-1:0] row_q,
  output logic [ADDR_W-1:0] col_q,
  output logic [NLANE-1:0]  drv_q,
  output logic [NLANE-1:0]  wr_q,
  output logic              ref_stb_q,
  output logic [ADDR_W-1:0] ref_row_q,
  output logic              ref_inc
);
  st_e               st_q, st_n;
  cyc_e              cyc_n;
  logic [ADDR_W-1:0] row_n, col_n, refrow_n;
  logic              ewr_q, ewr_n, ref_n, rd_ok;
  logic [NLANE-1:0]  wr_n, drv_n;

  always_comb begin
    st_n     = st_q;
    cyc_n    = cyc_q;
    row_n    = row_q;
    col_n    = col_q;
    ewr_n    = ewr_q;
    wr_n     = '0;
    ref_n    = 1'b0;
    refrow_n = ref_row_q;
    ref_inc  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (evt.ras_fall) begin
          ewr_n = 1'b0;
          if (evt.cas_act) begin
            st_n  = ST_CBR;
            cyc_n = CYC_CBR;
            row_n = ref_cnt;
          end else begin
            st_n  = ST_ROW;
            cyc_n = CYC_NONE;
            row_n = addr_s;
          end
        end
      end
      ST_CBR: begin
        if (evt.ras_rise) begin
          st_n     = ST_IDLE;
          ref_n    = 1'b1;
          refrow_n = ref_cnt;
          ref_inc  = 1'b1;
        end
      end
      default: begin
        if (evt.ras_rise) begin
          st_n     = ST_IDLE;
          ref_n    = 1'b1;
          refrow_n = row_q;
          if (st_q == ST_ROW) cyc_n = CYC_RASONLY;
        end else if (evt.cas_fall) begin
          st_n  = ST_ACC;
          col_n = addr_s;
          ewr_n = evt.we_low;
          if (evt.we_low)      cyc_n = CYC_EWR;
          else if (evt.oe_low) cyc_n = CYC_READ;
          else                 cyc_n = CYC_NONE;
        end else if (st_q == ST_ACC && evt.cas_act && !ewr_q) begin
          if (evt.we_fall && !evt.oe_low) begin
            cyc_n = CYC_LWR;
            wr_n  = lane_act;
          end else if (evt.oe_fall && !evt.we_low) begin
            cyc_n = CYC_READ;
          end
        end
      end
    endcase
    // early write: each lane strobes on its own fall while WE is low
    if (st_n == ST_ACC && evt.ras_act && evt.we_low) wr_n = wr_n | lane_fall;
    rd_ok = (st_n == ST_ACC) & evt.ras_act & evt.oe_low & ~evt.we_low & ~ewr_n;
    drv_n = rd_ok ? (lane_act | (drv_q & ~{NLANE{evt.cas_fall}})) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cyc_q     <= CYC_NONE;
      row_q     <= '0;
      col_q     <= '0;
      ewr_q     <= 1'b0;
      wr_q      <= '0;
      drv_q     <= '0;
      ref_stb_q <= 1'b0;
      ref_row_q <= '0;
    end else begin
      st_q      <= st_n;
      cyc_q     <= cyc_n;
      row_q     <= row_n;
      col_q     <= col_n;
      ewr_q     <= ewr_n;
      wr_q      <= wr_n;
      drv_q     <= drv_n;
      ref_stb_q <= ref_n;
      ref_row_q <= refrow_n;
    end
  end

  // R10
  drv_needs_ras_chk: assert property (@(posedge clk) disable iff (rst)
    (drv_q != '0) |-> $past(evt.ras_act));
  // R5
  no_drive_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_q != '0) |-> (drv_q == '0));
  // R2
  cbr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CBR) |-> (drv_q == '0 && wr_q == '0));
  // R11
  ref_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ref_stb_q |-> $past(evt.ras_rise));
endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
  import dsd_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              lcas_n,
  input  logic              ucas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [2:0]        cyc_type,
  output logic [ADDR_W-1:0] row_addr,
  output logic [ADDR_W-1:0] col_addr,
  output logic [LANES-1:0]  rd_lane_en,
  output logic [LANES-1:0]  wr_lane_stb,
  output logic              ref_stb,
  output logic [ADDR_W-1:0] ref_row
);
  evt_t              evt;
  logic [LANES-1:0]  lane_act, lane_fall;
  logic [ADDR_W-1:0] addr_s, ref_cnt;
  logic              ref_inc;
  cyc_e              cyc_w;

  dsd_pin_sampler #(.ADDR_W(ADDR_W), .NLANE(LANES)) u_sampler (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n({ucas_n, lcas_n}),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .evt(evt),
    .lane_act(lane_act), .lane_fall(lane_fall), .addr_s(addr_s)
  );

  dsd_refresh_ctr #(.REF_W(ADDR_W)) u_refctr (
    .clk(clk), .rst(rst), .inc(ref_inc), .cnt(ref_cnt)
  );

  dsd_cycle_fsm #(.ADDR_W(ADDR_W), .NLANE(LANES)) u_fsm (
    .clk(clk), .rst(rst), .evt(evt), .lane_act(lane_act),
    .lane_fall(lane_fall), .addr_s(addr_s), .ref_cnt(ref_cnt),
    .cyc_q(cyc_w), .row_q(row_addr), .col_q(col_addr), .drv_q(rd_lane_en),
    .wr_q(wr_lane_stb), .ref_stb_q(ref_stb), .ref_row_q(ref_row),
    .ref_inc(ref_inc)
  );

  assign cyc_type = cyc_w;
endmodule

// File: tb/test_dram_strobe_decoder.sv
`timescale 1ns/1ps
module test_dram_strobe_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [8:0] addr = '0;
  logic [2:0] cyc_type;
  logic [8:0] row_addr, col_addr, ref_row;
  logic [1:0] rd_lane_en, wr_lane_stb;
  logic       ref_stb;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2 clk = ~clk;

  dram_strobe_decoder i_dram_strobe_decoder (
    .clk(clk), .rst(rst), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .cyc_type(cyc_type),
    .row_addr(row_addr), .col_addr(col_addr), .rd_lane_en(rd_lane_en),
    .wr_lane_stb(wr_lane_stb), .ref_stb(ref_stb), .ref_row(ref_row)
  );

  // {req, ras, lcas, ucas, we, oe, addr, exp cyc, exp drv, exp wr, exp ref}
  localparam int NV = 22;
  localparam logic [25:0] VEC [NV] = '{
    {4'd7,  1'b0,1'b1,1'b1,1'b1,1'b1, 9'h055, 3'd0, 2'b00, 2'b00, 1'b0}, // R7 row open
    {4'd7,  1'b0,1'b0,1'b0,1'b1,1'b1, 9'h0A3, 3'd0, 2'b00, 2'b00, 1'b0}, // R7 CAS, OE high
    {4'd7,  1'b0,1'b0,1'b0,1'b1,1'b0, 9'h0A3, 3'd5, 2'b11, 2'b00, 1'b0}, // R7 OE falls later
    {4'd9,  1'b0,1'b1,1'b1,1'b1,1'b0, 9'h0A3, 3'd5, 2'b11, 2'b00, 1'b0}, // R9 hold over precharge
    {4'd8,  1'b0,1'b1,1'b0,1'b1,1'b0, 9'h011, 3'd5, 2'b10, 2'b00, 1'b0}, // R8 upper only
    {4'd10, 1'b1,1'b1,1'b1,1'b1,1'b0, 9'h011, 3'd5, 2'b00, 2'b00, 1'b1}, // R10 RAS high
    {4'd5,  1'b0,1'b1,1'b1,1'b1,1'b1, 9'h1F0, 3'd0, 2'b00, 2'b00, 1'b0}, // R5
    {4'd5,  1'b0,1'b0,1'b1,1'b0,1'b1, 9'h002, 3'd3, 2'b00, 2'b01, 1'b0}, // R5 early write
    {4'd5,  1'b0,1'b0,1'b1,1'b1,1'b0, 9'h002, 3'd3, 2'b00, 2'b00, 1'b0}, // R5 still no drive
    {4'd11, 1'b1,1'b1,1'b1,1'b1,1'b1, 9'h002, 3'd3, 2'b00, 2'b00, 1'b1}, // R11
    {4'd6,  1'b0,1'b1,1'b1,1'b1,1'b1, 9'h100, 3'd0, 2'b00, 2'b00, 1'b0}, // R6
    {4'd6,  1'b0,1'b0,1'b0,1'b1,1'b1, 9'h0FF, 3'd0, 2'b00, 2'b00, 1'b0}, // R6
    {4'd6,  1'b0,1'b0,1'b0,1'b0,1'b1, 9'h0FF, 3'd4, 2'b00, 2'b11, 1'b0}, // R6 late write
    {4'd6,  1'b0,1'b1,1'b1,1'b1,1'b1, 9'h0FF, 3'd4, 2'b00, 2'b00, 1'b0}, // R6
    {4'd7,  1'b0,1'b0,1'b1,1'b1,1'b0, 9'h0FF, 3'd5, 2'b01, 2'b00, 1'b0}, // R7 page read
    {4'd10, 1'b1,1'b1,1'b1,1'b1,1'b1, 9'h0FF, 3'd5, 2'b00, 2'b00, 1'b1}, // R10
    {4'd4,  1'b0,1'b1,1'b1,1'b1,1'b1, 9'h0C7, 3'd0, 2'b00, 2'b00, 1'b0}, // R4
    {4'd4,  1'b1,1'b1,1'b1,1'b1,1'b1, 9'h0C7, 3'd2, 2'b00, 2'b00, 1'b1}, // R4 row-only
    {4'd7,  1'b0,1'b1,1'b1,1'b1,1'b0, 9'h010, 3'd0, 2'b00, 2'b00, 1'b0}, // R7 OE first
    {4'd7,  1'b0,1'b1,1'b0,1'b1,1'b0, 9'h010, 3'd5, 2'b10, 2'b00, 1'b0}, // R7 CAS later
    {4'd8,  1'b0,1'b1,1'b0,1'b1,1'b1, 9'h010, 3'd5, 2'b00, 2'b00, 1'b0}, // R8 OE high
    {4'd11, 1'b1,1'b1,1'b1,1'b1,1'b1, 9'h010, 3'd5, 2'b00, 2'b00, 1'b1}  // R11
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic r, input logic l, input logic u,
                       input logic w, input logic o, input logic [8:0] a);
    ras_n = r; lcas_n = l; ucas_n = u; we_n = w; oe_n = o; addr = a;
    repeat (2) @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R12 reset state
    chk("R12", "cyc", 32'(cyc_type), 0);
    chk("R12", "drv", 32'(rd_lane_en), 0);
    chk("R12", "wr", 32'(wr_lane_stb), 0);
    chk("R12", "ref", 32'(ref_stb), 0);
    chk("R12", "refrow", 32'(ref_row), 0);
    chk("R12", "row", 32'(row_addr), 0);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      string rq;
      v = VEC[i];
      apply(v[21], v[20], v[19], v[18], v[17], v[16:8]);
      rq = $sformatf("R%0d row%0d", v[25:22], i);
      chk(rq, "cyc", 32'(cyc_type), 32'(v[7:5]));
      chk(rq, "drv", 32'(rd_lane_en), 32'(v[4:3]));
      chk(rq, "wr", 32'(wr_lane_stb), 32'(v[2:1]));
      chk(rq, "ref", 32'(ref_stb), 32'(v[0]));
    end

    // R1 first fall latches, last rise releases
    apply(0, 1, 1, 1, 1, 9'h044);
    chk("R11", "row", 32'(row_addr), 32'h044);
    apply(0, 0, 1, 1, 1, 9'h0AA);
    chk("R1", "col first fall", 32'(col_addr), 32'h0AA);
    apply(0, 0, 0, 1, 1, 9'h0BB);
    chk("R1", "col second lane", 32'(col_addr), 32'h0AA);
    apply(0, 1, 0, 1, 1, 9'h0CC);
    apply(0, 0, 0, 1, 1, 9'h0DD);
    chk("R1", "col upper held", 32'(col_addr), 32'h0AA);
    apply(0, 1, 1, 1, 1, 9'h0DD);
    apply(0, 0, 1, 1, 1, 9'h0EE);
    chk("R1", "col new fall", 32'(col_addr), 32'h0EE);
    apply(1, 1, 1, 1, 1, 9'h0EE);
    chk("R11", "ref", 32'(ref_stb), 1);
    chk("R11", "refrow", 32'(ref_row), 32'h044);

    // R6 WE fall with OE low gives no strobe
    apply(0, 1, 1, 1, 1, 9'h033);
    apply(0, 0, 0, 1, 0, 9'h001);
    chk("R7", "cyc", 32'(cyc_type), 5);
    apply(0, 0, 0, 0, 0, 9'h001);
    chk("R6", "wr oe low", 32'(wr_lane_stb), 0);
    chk("R6", "cyc oe low", 32'(cyc_type), 5);
    apply(1, 1, 1, 1, 1, 9'h001);

    // R4 row-only refresh reports its row
    apply(0, 1, 1, 1, 1, 9'h1A5);
    apply(1, 1, 1, 1, 1, 9'h000);
    chk("R4", "cyc", 32'(cyc_type), 2);
    chk("R4", "ref", 32'(ref_stb), 1);
    chk("R11", "refrow", 32'(ref_row), 32'h1A5);

    // R2 and R3: counter refresh through the wrap
    for (int k = 0; k <= 512; k++) begin
      apply(1, 0, 1, 1, 1, 9'h1FF);
      apply(0, 0, 1, 1, 0, 9'h123);
      chk("R2", "cyc", 32'(cyc_type), 1);
      chk("R2", "row", 32'(row_addr), 32'(k % 512));
      chk("R2", "drv", 32'(rd_lane_en), 0);
      apply(0, 0, 1, 1, 0, 9'h0F0);
      if (k < 2) chk("R2", "row addr ignored", 32'(row_addr), 32'(k % 512));
      apply(1, 0, 1, 1, 0, 9'h0F0);
      chk("R3", "ref", 32'(ref_stb), 1);
      chk("R3", "refrow", 32'(ref_row), 32'(k % 512));
      apply(1, 1, 1, 1, 1, 9'h000);
    end

    summary();
    $finish;
  end
endmodule